// File: doc/BRIEF.md
# RSA Key-Pair Selector

This block turns a pair of primes into a complete RSA key set. It takes the two primes as one request and forms their product, which is the modulus, and the product of each prime minus one, which is the totient. It then tries odd public exponents in rising order. For each candidate it runs an iterative extended Euclidean reduction of the totient against the candidate. It keeps the first candidate that is coprime to the totient and whose Bezout coefficient comes out non-negative. That coefficient is returned unchanged as the private exponent.

Both sides of the block use a valid/ready handshake. The block accepts a request only when it is idle, so `req_ready` is high exactly in that state. The result is offered on `key_valid` and stays on the pins, unchanged, until the consumer raises `key_ready`. A consumer may hold `key_ready` low for any number of cycles. During that time no new request is taken. Each quotient and remainder in the reduction comes from one shared restoring divider that needs a fixed number of steps.

If the search runs past the totient without finding a usable exponent, the block still completes the transfer, with an error flag set.

Top module: `rsa_key_select`

## Requirements
- R1: When a result is delivered, `key_n` equals `req_p`·`req_q` and the search was carried out against the totient (`req_p`−1)·(`req_q`−1). Both are 2·PW bits wide and use the operands captured at acceptance.
- R2: Candidate exponents are tried in the order 3, 5, 7, and so on, each one 2 above the last. Every delivered `key_e` is odd and at least 3.
- R3: A candidate is accepted only when the extended Euclidean reduction of (totient, candidate) ends with a GCD of 1 and a coefficient of the candidate that is not negative. The coefficient starts the pair (current, previous) at (1, 0). Each step sets it to (previous − quotient·current, current). The delivered `key_e` is the smallest accepted candidate, and `key_d` is its raw coefficient.
- R4: For every result with `key_err` = 0, `key_e`·`key_d` mod totient = 1.
- R5: For the primes 71 and 59, the result is `key_e` = 13 and `key_d` = 937, with `key_n` = 4189.
- R6: When the next candidate is greater than or equal to the totient, the search stops. The block delivers `key_err` = 1, `key_e` equal to that candidate, and `key_d` = 0.
- R7: Once `key_valid` is high, it stays high and all `key_*` outputs stay unchanged until a cycle with `key_ready` high. `key_valid` falls on the edge after that cycle. `req_ready` is never high while `key_valid` is high.
- R8: A request is taken only on an edge where `req_valid` and `req_ready` are both high. `req_ready` is low from the edge after acceptance until the result has been consumed. Operand values driven while `req_ready` is low have no effect on the result.
- R9: After reset, `req_ready` = 1 and `key_valid` = 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| req_valid | input | 1 | Request carries a prime pair |
| req_ready | output | 1 | Block is idle and takes the request |
| req_p | input | PW | First prime |
| req_q | input | PW | Second prime |
| key_valid | output | 1 | Result is present |
| key_ready | input | 1 | Consumer takes the result |
| key_n | output | 2·PW | Modulus |
| key_e | output | 2·PW | Public exponent (or out-of-range candidate on error) |
| key_d | output | 2·PW | Private exponent (zero on error) |
| key_err | output | 1 | No exponent found below the totient |

## Verification
Two decisions can fall on the same candidate. One is rejecting it for a negative coefficient. The other is finding that the next odd value already reaches the totient, so a rejection turns directly into an error delivery. Tiny prime pairs such as (3,3) and (2,7) provoke this, and the bench judges them by the reported candidate, a zero `key_d` and the error flag. The bench also overlaps new operands on the request pins during a search, and holds `key_ready` low while results wait. It judges these by an unchanged result and unchanged output pins.

// File: rtl/rks_pkg.sv
package rks_pkg;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_NEXT,
    ST_DIV,
    ST_WAIT,
    ST_JUDGE,
    ST_DONE
  } rks_state_e;

endpackage

// File: rtl/rks_setup.sv
module rks_setup #(
  parameter int PW = 32
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            load,
  input  logic [PW-1:0]   p,
  input  logic [PW-1:0]   q,
  output logic [2*PW-1:0] modulus,
  output logic [2*PW-1:0] totient
);
  localparam int NW = 2 * PW;

  logic [NW-1:0] p_ext, q_ext, pm1_ext, qm1_ext;

  always_comb begin
    p_ext   = {{PW{1'b0}}, p};
    q_ext   = {{PW{1'b0}}, q};
    pm1_ext = {{PW{1'b0}}, p - PW'(1)};
    qm1_ext = {{PW{1'b0}}, q - PW'(1)};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      modulus <= '0;
      totient <= '0;
    end else if (load) begin
      modulus <= p_ext * q_ext;
      totient <= pm1_ext * qm1_ext;
    end
  end
endmodule

// File: rtl/rks_divider.sv
module rks_divider #(
  parameter int W = 64
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         start,
  input  logic [W-1:0] dividend,
  input  logic [W-1:0] divisor,
  output logic         done,
  output logic [W-1:0] quo,
  output logic [W-1:0] rem
);
  localparam int CNTW = $clog2(W + 1);

  logic            busy_q;
  logic [CNTW-1:0] cnt_q;
  logic [W:0]      r_q;
  logic [W-1:0]    q_q;
  logic [W-1:0]    dv_q;
  logic            done_q;
  logic [W:0]      shifted, trial;

  always_comb begin
    shifted = {r_q[W-1:0], q_q[W-1]};
    trial   = shifted - {1'b0, dv_q};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy_q <= 1'b0;
      cnt_q  <= '0;
      r_q    <= '0;
      q_q    <= '0;
      dv_q   <= '0;
      done_q <= 1'b0;
    end else begin
      done_q <= 1'b0;
      if (start) begin
        busy_q <= 1'b1;
        cnt_q  <= '0;
        r_q    <= '0;
        q_q    <= dividend;
        dv_q   <= divisor;
      end else if (busy_q) begin
        if (!trial[W]) begin
          r_q <= trial;
          q_q <= {q_q[W-2:0], 1'b1};
        end else begin
          r_q <= shifted;
          q_q <= {q_q[W-2:0], 1'b0};
        end
        cnt_q <= cnt_q + CNTW'(1);
        if (cnt_q == CNTW'(W - 1)) begin
          busy_q <= 1'b0;
          done_q <= 1'b1;
        end
      end
    end
  end

  assign done = done_q;
  assign quo  = q_q;
  assign rem  = r_q[W-1:0];
endmodule

// File: rtl/rks_search.sv
module rks_search
  import rks_pkg::*;
#(
  parameter int NW = 64
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          req_valid,
  output logic          req_ready,
  output logic          load,
  input  logic [NW-1:0] totient,
  output logic          div_start,
  output logic [NW-1:0] div_a,
  output logic [NW-1:0] div_b,
  input  logic          div_done,
  input  logic [NW-1:0] div_quo,
  input  logic [NW-1:0] div_rem,
  output logic          key_valid,
  input  logic          key_ready,
  output logic [NW-1:0] key_e,
  output logic [NW-1:0] key_d,
  output logic          key_err
);
  localparam int CW = NW + 1;

  rks_state_e           state_q;
  logic [NW-1:0]        e_q, a_q, b_q, d_q;
  logic signed [CW-1:0] y_q, yp_q;
  logic                 err_q;

  logic [NW-1:0]        e_step;
  logic signed [CW-1:0] quo_s, prod, y_new;

  always_comb begin
    e_step = e_q + NW'(2);
    quo_s  = $signed({1'b0, div_quo});
    prod   = quo_s * y_q;
    y_new  = yp_q - prod;
  end

  assign req_ready = (state_q == ST_IDLE);
  assign load      = req_ready && req_valid;
  assign div_start = (state_q == ST_DIV);
  assign div_a     = a_q;
  assign div_b     = b_q;
  assign key_valid = (state_q == ST_DONE);
  assign key_e     = e_q;
  assign key_d     = d_q;
  assign key_err   = err_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_IDLE;
      e_q     <= '0;
      a_q     <= '0;
      b_q     <= '0;
      d_q     <= '0;
      y_q     <= '0;
      yp_q    <= '0;
      err_q   <= 1'b0;
    end else begin
      unique case (state_q)
        ST_IDLE: begin
          if (req_valid) begin
            e_q     <= NW'(1);
            err_q   <= 1'b0;
            d_q     <= '0;
            state_q <= ST_NEXT;
          end
        end
        ST_NEXT: begin
          e_q <= e_step;
          if (e_step >= totient) begin
            err_q   <= 1'b1;
            d_q     <= '0;
            state_q <= ST_DONE;
          end else begin
            a_q     <= totient;
            b_q     <= e_step;
            y_q     <= CW'(1);
            yp_q    <= '0;
            state_q <= ST_DIV;
          end
        end
        ST_DIV: state_q <= ST_WAIT;
        ST_WAIT: begin
          if (div_done) begin
            y_q     <= y_new;
            yp_q    <= y_q;
            a_q     <= b_q;
            b_q     <= div_rem;
            state_q <= (div_rem == '0) ? ST_JUDGE : ST_DIV;
          end
        end
        ST_JUDGE: begin
          if (a_q == NW'(1) && !yp_q[CW-1]) begin
            d_q     <= yp_q[NW-1:0];
            state_q <= ST_DONE;
          end else begin
            state_q <= ST_NEXT;
          end
        end
        ST_DONE: begin
          if (key_ready) state_q <= ST_IDLE;
        end
        default: state_q <= ST_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/rsa_key_select.sv
module rsa_key_select #(
  parameter int PW = 32,
  localparam int NW = 2 * PW
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          req_valid,
  output logic          req_ready,
  input  logic [PW-1:0] req_p,
  input  logic [PW-1:0] req_q,
  output logic          key_valid,
  input  logic          key_ready,
  output logic [NW-1:0] key_n,
  output logic [NW-1:0] key_e,
  output logic [NW-1:0] key_d,
  output logic          key_err
);
  logic          load;
  logic [NW-1:0] totient;
  logic          div_start, div_done;
  logic [NW-1:0] div_a, div_b, div_quo, div_rem;

  rks_setup #(.PW(PW)) u_setup (
    .clk     (clk),
    .rst_n   (rst_n),
    .load    (load),
    .p       (req_p),
    .q       (req_q),
    .modulus (key_n),
    .totient (totient)
  );

  rks_divider #(.W(NW)) u_div (
    .clk      (clk),
    .rst_n    (rst_n),
    .start    (div_start),
    .dividend (div_a),
    .divisor  (div_b),
    .done     (div_done),
    .quo      (div_quo),
    .rem      (div_rem)
  );

  rks_search #(.NW(NW)) u_search (
    .clk       (clk),
    .rst_n     (rst_n),
    .req_valid (req_valid),
    .req_ready (req_ready),
    .load      (load),
    .totient   (totient),
    .div_start (div_start),
    .div_a     (div_a),
    .div_b     (div_b),
    .div_done  (div_done),
    .div_quo   (div_quo),
    .div_rem   (div_rem),
    .key_valid (key_valid),
    .key_ready (key_ready),
    .key_e     (key_e),
    .key_d     (key_d),
    .key_err   (key_err)
  );
endmodule

// File: rtl/rks_checker.sv
module rks_checker #(
  parameter int PW = 32,
  localparam int NW = 2 * PW
) (
  input logic          clk,
  input logic          rst_n,
  input logic          req_valid,
  input logic          req_ready,
  input logic          key_valid,
  input logic          key_ready,
  input logic [NW-1:0] key_n,
  input logic [NW-1:0] key_e,
  input logic [NW-1:0] key_d,
  input logic          key_err
);
  // R7
  hold_result_chk: assert property (@(posedge clk) disable iff (!rst_n)
    key_valid && !key_ready |=> key_valid && $stable(key_n) && $stable(key_e)
                                && $stable(key_d) && $stable(key_err));

  // R7
  no_overlap_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(req_ready && key_valid));

  // R8
  busy_after_take_chk: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid && req_ready |=> !req_ready);

  // R6
  err_zero_d_chk: assert property (@(posedge clk) disable iff (!rst_n)
    key_valid && key_err |-> key_d == '0);

  // R2
  odd_exp_chk: assert property (@(posedge clk) disable iff (!rst_n)
    key_valid |-> key_e[0] && key_e >= NW'(3));

  // R3
  exp_below_mod_chk: assert property (@(posedge clk) disable iff (!rst_n)
    key_valid && !key_err |-> key_e < key_n);
endmodule

bind rsa_key_select rks_checker #(.PW(PW)) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .req_valid (req_valid),
  .req_ready (req_ready),
  .key_valid (key_valid),
  .key_ready (key_ready),
  .key_n     (key_n),
  .key_e     (key_e),
  .key_d     (key_d),
  .key_err   (key_err)
);

// File: tb/sim_rsa_key_select.sv
module sim_rsa_key_select;
  localparam int PW = 32;
  localparam int NW = 64;
  localparam int LIMIT = 190000;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          req_valid = 1'b0;
  logic          req_ready;
  logic [PW-1:0] req_p = '0;
  logic [PW-1:0] req_q = '0;
  logic          key_valid;
  logic          key_ready = 1'b0;
  logic [NW-1:0] key_n, key_e, key_d;
  logic          key_err;

  int n_chk = 0;
  int n_fail = 0;
  int cyc = 0;
  bit tmo = 1'b0;

  always #2 clk = ~clk;

  always @(posedge clk) begin
    cyc = cyc + 1;
    if (cyc >= LIMIT) tmo = 1'b1;
  end

  rsa_key_select #(.PW(PW)) u0 (
    .clk(clk), .rst_n(rst_n),
    .req_valid(req_valid), .req_ready(req_ready),
    .req_p(req_p), .req_q(req_q),
    .key_valid(key_valid), .key_ready(key_ready),
    .key_n(key_n), .key_e(key_e), .key_d(key_d), .key_err(key_err)
  );

  task automatic check(input string tag, input logic [127:0] act, input logic [127:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  function automatic void ref_key(input logic [NW-1:0] tot, output logic [NW-1:0] e,
                                  output logic [NW-1:0] d, output bit err);
    logic signed [131:0] r0, r1, t0, t1, qq, tmp;
    e = NW'(1);
    d = '0;
    err = 1'b0;
    while (1) begin
      e = e + NW'(2);
      if (e >= tot) begin
        err = 1'b1;
        d = '0;
        return;
      end
      r0 = 132'(tot);
      r1 = 132'(e);
      t0 = 0;
      t1 = 1;
      while (r1 != 0) begin
        qq  = r0 / r1;
        tmp = r0 - qq * r1;
        r0  = r1;
        r1  = tmp;
        tmp = t0 - qq * t1;
        t0  = t1;
        t1  = tmp;
      end
      if (r0 == 1 && t0 >= 0) begin
        d = t0[NW-1:0];
        return;
      end
    end
  endfunction

  task automatic run_pair(input logic [PW-1:0] p, input logic [PW-1:0] q, input bit stall);
    logic [NW-1:0] exp_n, tot, exp_e, exp_d;
    logic [127:0]  prodv;
    bit            exp_err;
    logic [NW-1:0] hold_e;
    exp_n = {32'b0, p} * {32'b0, q};
    tot   = {32'b0, p - 32'd1} * {32'b0, q - 32'd1};
    ref_key(tot, exp_e, exp_d, exp_err);

    @(negedge clk);
    req_valid = 1'b1;
    req_p = p;
    req_q = q;
    @(negedge clk);
    // R8: new operands while busy must be ignored
    req_p = ~p;
    req_q = q ^ 32'h5a5a_0f0f;
    check("R8 req_ready low after accept", 128'(req_ready), 128'(0));
    repeat (4) @(negedge clk);
    req_valid = 1'b0;

    while (!key_valid && !tmo) @(negedge clk);
    if (tmo) begin
      check("R1 watchdog expired", 128'(1), 128'(0));
      return;
    end
    check("R1 R8 modulus", 128'(key_n), 128'(exp_n));
    check("R2 R3 public exponent", 128'(key_e), 128'(exp_e));
    check("R3 private exponent", 128'(key_d), 128'(exp_d));
    check("R6 error flag", 128'(key_err), 128'(exp_err));
    if (!exp_err) begin
      prodv = ({64'b0, key_e} * {64'b0, key_d}) % {64'b0, tot};
      check("R4 inverse product", prodv, 128'(1));
    end
    check("R7 req_ready low while result waits", 128'(req_ready), 128'(0));

    if (stall) begin
      hold_e = key_e;
      repeat (3) @(negedge clk);
      check("R7 valid held under stall", 128'(key_valid), 128'(1));
      check("R7 exponent held under stall", 128'(key_e), 128'(hold_e));
    end

    key_ready = 1'b1;
    @(negedge clk);
    key_ready = 1'b0;
    check("R7 valid drops after take", 128'(key_valid), 128'(0));
    check("R7 idle after take", 128'(req_ready), 128'(1));
  endtask

  initial begin
    int pr[7];
    pr = '{2, 3, 5, 7, 11, 13, 17};
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    check("R9 reset req_ready", 128'(req_ready), 128'(1));
    check("R9 reset key_valid", 128'(key_valid), 128'(0));

    // R5 known pair
    run_pair(32'd71, 32'd59, 1'b1);
    if (!tmo) begin
      check("R5 e for 71,59", 128'(key_e), 128'(13));
      check("R5 d for 71,59", 128'(key_d), 128'(937));
    end

    // R6 candidate rejected then range exhausted
    run_pair(32'd3, 32'd3, 1'b0);

    for (int i = 0; i < 7; i++) begin
      for (int j = 0; j < 7; j++) begin
        if (!tmo) run_pair(32'(pr[i]), 32'(pr[j]), ((i + j) % 3) == 0);
      end
    end

    if (!tmo) run_pair(32'd4294967291, 32'd4294967279, 1'b1);
    if (!tmo) run_pair(32'd101, 32'd103, 1'b0);

    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule